// File: doc/BRIEF.md
# I2C Write Chunking Sequencer

This block turns one I2C master write message into a series of short commands for a byte-oriented master engine that holds at most four bytes per command. The caller starts a message with a target address byte, a payload length and a flag that says whether the message ends with a STOP. Payload bytes then arrive one per handshake. The sequencer packs the address and the payload into 32-bit words. The earliest byte goes in the least significant position. Each word is issued with its byte count and its condition flags.

The address byte travels in the first command, together with up to three payload bytes. Every later command carries up to four bytes. A short final command is shifted right so that its first byte sits in bits 7:0. After each command the sequencer waits for the engine to report completion. It stops early if the engine reports a missing acknowledge or takes too long. It then signals the end of the message with a single-cycle `done` and sticky error flags.

Top module: `wrchunk_seq`

## Requirements
- R1: A `start` with `msg_len` equal to 0 issues no command. One cycle later it produces `done` with `err_len` set.
- R2: The bus byte order is the address first, then payload bytes in arrival order. Within a command word, byte k of the command sits in bits 8k+7:8k. A command with fewer than four bytes holds its first byte in bits 7:0.
- R3: Take the sequence formed by the address followed by the payload. Each consecutive group of four bytes of that sequence forms one command. The final group may be shorter. `cmd_count` carries the group size (1 to 4). For payload index i, a command leaves when i mod 4 is 2 or i is the last index.
- R4: `cmd_start` is 1 on the first command of a message and 0 on every other command.
- R5: If the payload is longer than 3 bytes, `cmd_hold` is 1 on every command except the final one. On the final command, and on every command of a shorter message, it is 0.
- R6: `cmd_stop` is 1 only on the final command of a message, and only when `stop_req` was 1 at `start`.
- R7: Every command has `cmd_master` and `cmd_tx` at 1.
- R8: After issuing a command, the sequencer accepts no payload byte (`in_ready` is 0) and issues no command until `eng_done` is seen.
- R9: An `eng_done` with `eng_nak` set ends the message. `done` and `err_nak` are produced, no further command is issued, and no further payload byte is taken.
- R10: If `eng_done` has not arrived `TIMEOUT_CYC` cycles after a command is issued, the message ends with `done` and `err_timeout`. `done` rises exactly `TIMEOUT_CYC` cycles after `cmd_go`.
- R11: After the final command's `eng_done` without NAK, `done` pulses with all error flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a message; ignored while busy |
| addr_byte | input | 8 | Address byte sent first |
| msg_len | input | LEN_W | Payload byte count |
| stop_req | input | 1 | End the message with a STOP |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted this cycle when valid |
| cmd_go | output | 1 | One-cycle command issue strobe |
| cmd_data | output | 32 | Packed command bytes, LSB first |
| cmd_count | output | 3 | Bytes in the command |
| cmd_start | output | 1 | Request START before the command |
| cmd_stop | output | 1 | Request STOP after the command |
| cmd_hold | output | 1 | Hold the clock low after the command |
| cmd_master | output | 1 | Master mode |
| cmd_tx | output | 1 | Transmit direction |
| eng_done | input | 1 | Engine finished the command |
| eng_nak | input | 1 | NAK status, valid with eng_done |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle end-of-message strobe |
| err_nak | output | 1 | Message ended on NAK |
| err_timeout | output | 1 | Message ended on timeout |
| err_len | output | 1 | Zero-length message rejected |

## Verification
The hardest case to reach is an abort in the middle of a message. There the check must show that the payload bytes after the failing command stay unconsumed, and that the exact cycle of the timeout end is right. The bench engine model counts commands. It raises NAK on a chosen command, or withholds completion on a chosen command. The byte feeder counts accepted bytes, so the consumed count is compared with the bytes of the chunks issued so far. Lengths 1 to 12 are swept with and without STOP and with and without input gaps, so every chunk shape is covered: short first chunk, full middle chunks, and final chunks of 1 to 4 bytes.

// File: rtl/wrchunk_seq.sv
module wrchunk_seq #(
  parameter int LEN_W       = 16,
  parameter int TIMEOUT_CYC = 1000,
  localparam int TMO_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       addr_byte,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             stop_req,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             cmd_go,
  output logic [31:0]      cmd_data,
  output logic [2:0]       cmd_count,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_hold,
  output logic             cmd_master,
  output logic             cmd_tx,
  input  logic             eng_done,
  input  logic             eng_nak,
  output logic             busy,
  output logic             done,
  output logic             err_nak,
  output logic             err_timeout,
  output logic             err_len
);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WAIT} st_t;

  st_t              st_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic             stop_q, first_q, last_q;
  logic [31:0]      shift_q;
  logic [TMO_W-1:0] tmo_q;

  logic [31:0] shifted, aligned;
  logic [2:0]  xlen;
  logic        is_last, xmit, accept, long_msg;

  assign in_ready = (st_q == S_FILL);
  assign busy     = (st_q != S_IDLE);
  assign accept   = in_ready && in_valid;
  assign shifted  = {in_data, shift_q[31:8]};
  assign is_last  = (idx_q == len_q - LEN_W'(1));
  assign xmit     = is_last || (idx_q[1:0] == 2'd2);
  assign long_msg = (len_q > LEN_W'(3));

  always_comb begin
    case (idx_q[1:0])
      2'd0:    begin xlen = 3'd2; aligned = shifted >> 16; end
      2'd1:    begin xlen = 3'd3; aligned = shifted >> 8;  end
      2'd2:    begin xlen = 3'd4; aligned = shifted;       end
      default: begin xlen = 3'd1; aligned = shifted >> 24; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      len_q       <= '0;
      idx_q       <= '0;
      stop_q      <= 1'b0;
      first_q     <= 1'b0;
      last_q      <= 1'b0;
      shift_q     <= '0;
      tmo_q       <= '0;
      cmd_go      <= 1'b0;
      cmd_data    <= '0;
      cmd_count   <= '0;
      cmd_start   <= 1'b0;
      cmd_stop    <= 1'b0;
      cmd_hold    <= 1'b0;
      cmd_master  <= 1'b0;
      cmd_tx      <= 1'b0;
      done        <= 1'b0;
      err_nak     <= 1'b0;
      err_timeout <= 1'b0;
      err_len     <= 1'b0;
    end else begin
      cmd_go <= 1'b0;
      done   <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          err_nak     <= 1'b0;
          err_timeout <= 1'b0;
          err_len     <= 1'b0;
          if (msg_len == '0) begin
            err_len <= 1'b1;
            done    <= 1'b1;
          end else begin
            st_q    <= S_FILL;
            len_q   <= msg_len;
            stop_q  <= stop_req;
            idx_q   <= '0;
            first_q <= 1'b1;
            shift_q <= {addr_byte, 24'd0};
          end
        end
        S_FILL: if (accept) begin
          shift_q <= shifted;
          idx_q   <= idx_q + LEN_W'(1);
          if (xmit) begin
            cmd_go     <= 1'b1;
            cmd_data   <= aligned;
            cmd_count  <= xlen;
            cmd_start  <= first_q;
            cmd_hold   <= long_msg && !is_last;
            cmd_stop   <= is_last && stop_q;
            cmd_master <= 1'b1;
            cmd_tx     <= 1'b1;
            first_q    <= 1'b0;
            last_q     <= is_last;
            tmo_q      <= '0;
            st_q       <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (eng_done) begin
            if (eng_nak) begin
              err_nak <= 1'b1;
              done    <= 1'b1;
              st_q    <= S_IDLE;
            end else if (last_q) begin
              done <= 1'b1;
              st_q <= S_IDLE;
            end else begin
              st_q <= S_FILL;
            end
          end else if (tmo_q == TMO_W'(TIMEOUT_CYC - 1)) begin
            err_timeout <= 1'b1;
            done        <= 1'b1;
            st_q        <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + TMO_W'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wrchunk_seq_chk.sv
module wrchunk_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] msg_len,
  input logic             in_ready,
  input logic             cmd_go,
  input logic [2:0]       cmd_count,
  input logic             cmd_stop,
  input logic             cmd_hold,
  input logic             cmd_master,
  input logic             cmd_tx,
  input logic             busy,
  input logic             done,
  input logic             err_nak,
  input logic             err_timeout,
  input logic             err_len
);

  AST_ZERO_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && msg_len == '0) |=> (done && err_len && !cmd_go)); // R1

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (cmd_count >= 3'd1 && cmd_count <= 3'd4)); // R3

  AST_STOP_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && cmd_stop) |-> !cmd_hold); // R6

  AST_MASTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (cmd_master && cmd_tx)); // R7

  AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (!in_ready && busy)); // R8

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({err_nak, err_timeout, err_len}) <= 1)); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cmd_go)); // R11

endmodule

bind wrchunk_seq wrchunk_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
  .in_ready(in_ready), .cmd_go(cmd_go), .cmd_count(cmd_count),
  .cmd_stop(cmd_stop), .cmd_hold(cmd_hold), .cmd_master(cmd_master),
  .cmd_tx(cmd_tx), .busy(busy), .done(done), .err_nak(err_nak),
  .err_timeout(err_timeout), .err_len(err_len)
);

// File: tb/wrchunk_seq_tb.sv
module wrchunk_seq_tb_top;
  localparam int LEN_W = 8;
  localparam int TMO   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] addr_byte = '0;
  logic [LEN_W-1:0] msg_len = '0;
  logic stop_req = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic cmd_go;
  logic [31:0] cmd_data;
  logic [2:0] cmd_count;
  logic cmd_start, cmd_stop, cmd_hold, cmd_master, cmd_tx;
  logic eng_done = 1'b0;
  logic eng_nak = 1'b0;
  logic busy, done, err_nak, err_timeout, err_len;

  always #10 clk = ~clk;

  wrchunk_seq #(.LEN_W(LEN_W), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_byte(addr_byte),
    .msg_len(msg_len), .stop_req(stop_req), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cmd_go(cmd_go),
    .cmd_data(cmd_data), .cmd_count(cmd_count), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_hold(cmd_hold), .cmd_master(cmd_master),
    .cmd_tx(cmd_tx), .eng_done(eng_done), .eng_nak(eng_nak), .busy(busy),
    .done(done), .err_nak(err_nak), .err_timeout(err_timeout),
    .err_len(err_len)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] pay [0:15];
  logic [7:0] sb  [0:16];
  logic [31:0] e_data [0:7];
  int e_cnt [0:7];
  int n_chunks, seen, fed, tcnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic feeder(input int len, input bit gap);
    int c = 0;
    forever begin
      @(negedge clk);
      if (done || fed >= len) begin in_valid = 1'b0; break; end
      begin
        bit acc;
        in_valid = !(gap && c[0]);
        in_data  = pay[fed];
        acc = in_valid && in_ready;
        c++;
        @(posedge clk);
        if (acc) fed++;
      end
    end
  endtask

  task automatic engine(input int len, input bit stp, input int nak_at, input int hang_at);
    int dly = 0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0; eng_nak = 1'b0;
      tcnt++;
      if (done) break;
      if (cmd_go) begin
        bit lst;
        lst = (seen == n_chunks - 1);
        if (seen < 8) begin
          chk("R2 data", cmd_data, e_data[seen]);
          chk("R3 count", 32'(cmd_count), 32'(e_cnt[seen]));
        end
        chk("R4 start", 32'(cmd_start), 32'(seen == 0));
        chk("R5 hold", 32'(cmd_hold), 32'(len > 3 && !lst));
        chk("R6 stop", 32'(cmd_stop), 32'(lst && stp));
        chk("R7 master/tx", {30'd0, cmd_master, cmd_tx}, 32'd3);
        chk("R8 ready low", 32'(in_ready), 32'd0);
        tcnt = 0;
        dly = (seen == hang_at) ? -1 : 1 + (seen % 3);
        seen++;
      end else if (dly > 0) begin
        dly--;
        if (dly == 0) begin
          eng_done = 1'b1;
          eng_nak  = (seen - 1 == nak_at);
        end
      end
    end
  endtask

  task automatic run_msg(input int len, input bit stp, input bit gap,
                         input int nak_at, input int hang_at);
    int total, exp_chunks, exp_fed;
    logic [7:0] ad;
    ad = 8'hA0 + 8'(len);
    for (int k = 0; k < len; k++) pay[k] = 8'((k * 29 + len * 7 + 1) & 255);
    sb[0] = ad;
    for (int k = 0; k < len; k++) sb[k+1] = pay[k];
    total = len + 1;
    n_chunks = (total + 3) / 4;
    for (int j = 0; j < n_chunks; j++) begin
      e_data[j] = '0;
      e_cnt[j] = 0;
      for (int p = 4 * j; p < 4 * j + 4 && p < total; p++) begin
        e_data[j] = e_data[j] | (32'(sb[p]) << (8 * (p - 4 * j)));
        e_cnt[j]++;
      end
    end
    seen = 0; fed = 0; tcnt = 0;
    @(negedge clk);
    start = 1'b1; addr_byte = ad; msg_len = LEN_W'(len); stop_req = stp;
    @(negedge clk);
    start = 1'b0;
    fork
      feeder(len, gap);
      engine(len, stp, nak_at, hang_at);
    join
    if (nak_at >= 0 && nak_at < n_chunks) begin
      exp_chunks = nak_at + 1;
      exp_fed = ((4 * exp_chunks < total) ? 4 * exp_chunks : total) - 1;
      chk("R9 chunks", 32'(seen), 32'(exp_chunks));
      chk("R9 fed", 32'(fed), 32'(exp_fed));
      chk("R9 err", {29'd0, err_nak, err_timeout, err_len}, 32'd4);
    end else if (hang_at >= 0 && hang_at < n_chunks) begin
      chk("R10 chunks", 32'(seen), 32'(hang_at + 1));
      chk("R10 cycles", 32'(tcnt), 32'(TMO));
      chk("R10 err", {29'd0, err_nak, err_timeout, err_len}, 32'd2);
    end else begin
      chk("R3 chunks", 32'(seen), 32'(n_chunks));
      chk("R11 fed", 32'(fed), 32'(len));
      chk("R11 err", {29'd0, err_nak, err_timeout, err_len}, 32'd0);
    end
    @(negedge clk);
    chk("R11 idle", {30'd0, busy, in_ready}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset", {27'd0, busy, in_ready, cmd_go, done, err_len}, 32'd0);
    rst_n = 1'b1;
    // R1: zero length
    @(negedge clk);
    start = 1'b1; msg_len = '0; addr_byte = 8'h5A;
    @(negedge clk);
    start = 1'b0;
    chk("R1 done/err_len", {29'd0, done, err_len, cmd_go}, 32'd6);
    chk("R1 no accept", {30'd0, busy, in_ready}, 32'd0);
    for (int len = 1; len <= 12; len++)
      for (int m = 0; m < 4; m++)
        run_msg(len, m[0], m[1], -1, -1);
    for (int j = 0; j < 4; j++) run_msg(13, 1'b1, 1'b0, j, -1);
    run_msg(2, 1'b1, 1'b0, 0, -1);
    run_msg(9, 1'b0, 1'b0, -1, 1);
    run_msg(3, 1'b1, 1'b1, -1, 0);
    run_msg(7, 1'b1, 1'b0, -1, -1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule